// File: doc/BRIEF.md
# Two-Wire Bus Condition Sequencer

This block is the control and line-condition engine of a two-wire (I2C-style) controller. Software uses a small register port to set four control bits: interrupt enable, bus enable, a start request and a stop request. The engine drives the SDA and SCL lines as open-drain pull-low enables and watches both lines to tell whether the bus is free. It produces START, repeated START and STOP conditions, and it keeps track of whether the controller is master, slave or idle.

The byte engine around this block provides the other inputs. It signals that a byte has completed, that the controller has been addressed as a slave, and that the interrupt flag is raised. The start and stop request bits clear themselves once they have been served. A start request made while a slave transfer is in progress waits until the bus is released. A stop request made in slave mode only resets the internal mode. When start and stop are both requested, the STOP is sent first and the START follows.

Top module: `twb_cond_seq`

## Requirements
- R1: After reset, every control bit reads 0, both line enables are 0, the mode is idle (mode code 00) and the bus is reported free.
- R2: The control word layout is bit0 interrupt enable, bit1 bus enable, bit2 start request, bit3 stop request. The interrupt output is high one cycle after a cycle in which interrupt enable and the interrupt flag input are both 1, and it is low otherwise.
- R3: While bus enable is 0, a START seen on the lines does not mark the bus busy, the slave-addressed input does not change the mode, and no condition is driven, even when a start request is pending.
- R4: A start request with bus enable 1, idle mode and a free bus produces a START on the lines: SDA is pulled low while SCL is high for at least PHASE_CYC cycles, then SCL is pulled low and the mode becomes master (code 01).
- R5: The start request bit reads 0 once its START has been sent. Writing 0 to the start or stop bit never clears a pending request.
- R6: In master mode, a start request produces a repeated START only after at least one byte has completed since the last START. Until then the request stays pending and the lines do not change.
- R7: A start request made in slave mode (code 10) waits with both line enables at 0 until a STOP is seen on the lines. After that the START is issued and the mode becomes master.
- R8: A stop request in master mode produces a STOP on the lines (SDA rising while SCL is high). The block then releases both lines, returns to idle, clears the stop bit and reports the bus free.
- R9: A stop request in slave mode returns the block to idle and clears the stop bit without driving any condition on the lines.
- R10: When start and stop are both requested in master mode, a STOP appears on the lines before the next START, and the block ends in master mode with both request bits cleared.
- R11: With bus enable 1, a START seen on the lines (SDA falling while SCL is high) marks the bus busy, and a STOP seen on the lines marks it free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 4 | Control word write data |
| reg_rdata_o | output | 4 | Control word readback |
| int_flag_i | input | 1 | Interrupt flag from the byte engine |
| byte_done_i | input | 1 | One-cycle pulse: a byte has completed |
| slave_hit_i | input | 1 | One-cycle pulse: the controller has been addressed as a slave |
| sda_i | input | 1 | Sampled SDA line level |
| scl_i | input | 1 | Sampled SCL line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| irq_o | output | 1 | Interrupt output |
| mode_o | output | 2 | Mode: 00 idle, 01 master, 10 slave |
| bus_free_o | output | 1 | Bus free indication |

## Verification
A wrong mode shows up at the ports. A request bit stays set in the readback when it should have cleared, or a condition appears or goes missing on the looped-back lines, or it comes in the wrong order. Each of these is visible within a few phase periods of the request. A wrong bus-free state shows up in the next cycle on the bus-free output, and the bench sees it as a START that is held back or issued too early. A bad phase counter changes how long SDA stays low while SCL is high, and the bench measures that time directly on the lines.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int REG_W      = 4;
  localparam int BIT_IRQEN  = 0;
  localparam int BIT_BUSEN  = 1;
  localparam int BIT_START  = 2;
  localparam int BIT_STOP   = 3;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_MASTER = 2'b01,
    MODE_SLAVE  = 2'b10
  } twb_mode_e;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_START  = 2'b01,
    CMD_RSTART = 2'b10,
    CMD_STOP   = 2'b11
  } twb_cmd_e;

  typedef enum logic [3:0] {
    G_IDLE       = 4'd0,
    G_ST_SETUP   = 4'd1,
    G_ST_HOLD    = 4'd2,
    G_ST_LOCK    = 4'd3,
    G_OWN        = 4'd4,
    G_RS_REL_SDA = 4'd5,
    G_RS_REL_SCL = 4'd6,
    G_SP_LOW     = 4'd7,
    G_SP_SCL     = 4'd8,
    G_SP_SDA     = 4'd9
  } twb_gen_e;
endpackage

// File: rtl/twb_ctrl_reg.sv
module twb_ctrl_reg
  import twb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             clr_start,
  input  logic             clr_stop,
  output logic             irq_en,
  output logic             bus_en,
  output logic             start_req,
  output logic             stop_req
);
  logic irq_en_q, bus_en_q, start_q, stop_q;
  logic irq_en_d, bus_en_d, start_d, stop_d;

  always_comb begin
    irq_en_d = irq_en_q;
    bus_en_d = bus_en_q;
    start_d  = start_q & ~clr_start;
    stop_d   = stop_q & ~clr_stop;
    if (wr_en) begin
      irq_en_d = wdata[BIT_IRQEN];
      bus_en_d = wdata[BIT_BUSEN];
      start_d  = start_d | wdata[BIT_START];
      stop_d   = stop_d | wdata[BIT_STOP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= 1'b0;
      bus_en_q <= 1'b0;
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      irq_en_q <= irq_en_d;
      bus_en_q <= bus_en_d;
      start_q  <= start_d;
      stop_q   <= stop_d;
    end
  end

  assign irq_en    = irq_en_q;
  assign bus_en    = bus_en_q;
  assign start_req = start_q;
  assign stop_req  = stop_q;

  AST_START_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !clr_start) |=> start_q); // R5
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !clr_stop) |=> stop_q); // R5
endmodule

// File: rtl/twb_bus_monitor.sv
module twb_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en,
  input  logic sda_i,
  input  logic scl_i,
  output logic start_det,
  output logic stop_det,
  output logic bus_free
);
  logic sda_q, scl_q, free_q, free_d;
  logic scl_high;

  assign scl_high  = scl_q & scl_i;
  assign start_det = bus_en & scl_high & sda_q & ~sda_i;
  assign stop_det  = bus_en & scl_high & ~sda_q & sda_i;

  always_comb begin
    free_d = free_q;
    if (start_det)     free_d = 1'b0;
    else if (stop_det) free_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q  <= 1'b1;
      scl_q  <= 1'b1;
      free_q <= 1'b1;
    end else begin
      sda_q  <= sda_i;
      scl_q  <= scl_i;
      free_q <= free_d;
    end
  end

  assign bus_free = free_q;

  AST_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> free_q); // R11
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !free_q); // R11
endmodule

// File: rtl/twb_cond_gen.sv
module twb_cond_gen
  import twb_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  twb_cmd_e cmd,
  output logic     gen_idle,
  output logic     gen_own,
  output logic     start_done,
  output logic     stop_done,
  output logic     sda_oe,
  output logic     scl_oe
);
  localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);

  twb_gen_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_done_q, start_done_d;
  logic             stop_done_q, stop_done_d;
  logic             last, timed;

  assign last  = (cnt_q == CNT_LAST);
  assign timed = (state_q != G_IDLE) && (state_q != G_OWN);

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    start_done_d = 1'b0;
    stop_done_d  = 1'b0;
    if (timed) cnt_d = last ? '0 : cnt_q + 1'b1;
    case (state_q)
      G_IDLE:       if (cmd_valid && cmd == CMD_START) state_d = G_ST_SETUP;
      G_ST_SETUP:   if (last) state_d = G_ST_HOLD;
      G_ST_HOLD:    if (last) state_d = G_ST_LOCK;
      G_ST_LOCK: begin
        if (last) begin
          state_d      = G_OWN;
          start_done_d = 1'b1;
        end
      end
      G_OWN: begin
        if (cmd_valid && cmd == CMD_RSTART)    state_d = G_RS_REL_SDA;
        else if (cmd_valid && cmd == CMD_STOP) state_d = G_SP_LOW;
      end
      G_RS_REL_SDA: if (last) state_d = G_RS_REL_SCL;
      G_RS_REL_SCL: if (last) state_d = G_ST_HOLD;
      G_SP_LOW:     if (last) state_d = G_SP_SCL;
      G_SP_SCL:     if (last) state_d = G_SP_SDA;
      G_SP_SDA: begin
        if (last) begin
          state_d     = G_IDLE;
          stop_done_d = 1'b1;
        end
      end
      default:      state_d = G_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= G_IDLE;
      cnt_q        <= '0;
      start_done_q <= 1'b0;
      stop_done_q  <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      start_done_q <= start_done_d;
      stop_done_q  <= stop_done_d;
    end
  end

  always_comb begin
    sda_oe = 1'b0;
    scl_oe = 1'b0;
    case (state_q)
      G_ST_HOLD:    sda_oe = 1'b1;
      G_ST_LOCK:    begin sda_oe = 1'b1; scl_oe = 1'b1; end
      G_OWN:        begin sda_oe = 1'b1; scl_oe = 1'b1; end
      G_RS_REL_SDA: scl_oe = 1'b1;
      G_SP_LOW:     begin sda_oe = 1'b1; scl_oe = 1'b1; end
      G_SP_SCL:     sda_oe = 1'b1;
      default:      begin sda_oe = 1'b0; scl_oe = 1'b0; end
    endcase
  end

  assign gen_idle   = (state_q == G_IDLE);
  assign gen_own    = (state_q == G_OWN);
  assign start_done = start_done_q;
  assign stop_done  = stop_done_q;

  AST_STOP_ENDS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done_q |-> (!sda_oe && !scl_oe)); // R8
  AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_done_q && stop_done_q)); // R10
endmodule

// File: rtl/twb_mode_ctl.sv
module twb_mode_ctl
  import twb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_en,
  input  logic      start_req,
  input  logic      stop_req,
  input  logic      slave_hit,
  input  logic      byte_done,
  input  logic      line_stop,
  input  logic      bus_free,
  input  logic      gen_idle,
  input  logic      gen_own,
  input  logic      start_done,
  input  logic      stop_done,
  output logic      cmd_valid,
  output twb_cmd_e  cmd,
  output logic      clr_start,
  output logic      clr_stop,
  output twb_mode_e mode
);
  twb_mode_e mode_q, mode_d;
  logic      byte_seen_q, byte_seen_d;

  always_comb begin
    mode_d      = mode_q;
    byte_seen_d = byte_seen_q | (byte_done && mode_q == MODE_MASTER);
    cmd_valid   = 1'b0;
    cmd         = CMD_NONE;
    clr_start   = 1'b0;
    clr_stop    = 1'b0;
    case (mode_q)
      MODE_IDLE: begin
        if (start_done) begin
          mode_d      = MODE_MASTER;
          clr_start   = 1'b1;
          byte_seen_d = 1'b0;
        end else if (stop_req) begin
          clr_stop = 1'b1;
        end else if (start_req && bus_en && bus_free && gen_idle) begin
          cmd_valid = 1'b1;
          cmd       = CMD_START;
        end else if (slave_hit && bus_en && gen_idle) begin
          mode_d = MODE_SLAVE;
        end
      end
      MODE_MASTER: begin
        if (stop_done) begin
          mode_d   = MODE_IDLE;
          clr_stop = 1'b1;
        end else if (start_done) begin
          clr_start   = 1'b1;
          byte_seen_d = 1'b0;
        end else if (gen_own && stop_req) begin
          cmd_valid = 1'b1;
          cmd       = CMD_STOP;
        end else if (gen_own && start_req && byte_seen_q) begin
          cmd_valid = 1'b1;
          cmd       = CMD_RSTART;
        end
      end
      MODE_SLAVE: begin
        if (stop_req) begin
          mode_d   = MODE_IDLE;
          clr_stop = 1'b1;
        end else if (line_stop || !bus_en) begin
          mode_d = MODE_IDLE;
        end
      end
      default: mode_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_IDLE;
      byte_seen_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      byte_seen_q <= byte_seen_d;
    end
  end

  assign mode = mode_q;

  AST_MASTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q == MODE_MASTER) |-> $past(start_done)); // R4
  AST_START_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_START) |-> bus_free); // R4
  AST_SLAVE_STOP_INTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLAVE && stop_req) |=> (mode_q == MODE_IDLE)); // R9
endmodule

// File: rtl/twb_cond_seq.sv
module twb_cond_seq
  import twb_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             int_flag_i,
  input  logic             byte_done_i,
  input  logic             slave_hit_i,
  input  logic             sda_i,
  input  logic             scl_i,
  output logic             sda_oe_o,
  output logic             scl_oe_o,
  output logic             irq_o,
  output logic [1:0]       mode_o,
  output logic             bus_free_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       irq_en, bus_en, start_req, stop_req;
  logic       clr_start, clr_stop;
  logic       line_start, line_stop, bus_free;
  logic       gen_idle, gen_own, start_done, stop_done;
  logic       cmd_valid;
  twb_cmd_e   cmd;
  twb_mode_e  mode;
  logic       irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  twb_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(reg_wr_i), .wdata(reg_wdata_i),
    .clr_start(clr_start), .clr_stop(clr_stop),
    .irq_en(irq_en), .bus_en(bus_en), .start_req(start_req), .stop_req(stop_req)
  );

  twb_bus_monitor u_mon (
    .clk(clk), .rst_n(rst_n_s), .bus_en(bus_en), .sda_i(sda_i), .scl_i(scl_i),
    .start_det(line_start), .stop_det(line_stop), .bus_free(bus_free)
  );

  twb_cond_gen #(.PHASE_CYC(PHASE_CYC)) u_gen (
    .clk(clk), .rst_n(rst_n_s), .cmd_valid(cmd_valid), .cmd(cmd),
    .gen_idle(gen_idle), .gen_own(gen_own),
    .start_done(start_done), .stop_done(stop_done),
    .sda_oe(sda_oe_o), .scl_oe(scl_oe_o)
  );

  twb_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n_s), .bus_en(bus_en),
    .start_req(start_req), .stop_req(stop_req),
    .slave_hit(slave_hit_i), .byte_done(byte_done_i),
    .line_stop(line_stop), .bus_free(bus_free),
    .gen_idle(gen_idle), .gen_own(gen_own),
    .start_done(start_done), .stop_done(stop_done),
    .cmd_valid(cmd_valid), .cmd(cmd),
    .clr_start(clr_start), .clr_stop(clr_stop), .mode(mode)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_en & int_flag_i;
  end

  always_comb begin
    reg_rdata_o            = '0;
    reg_rdata_o[BIT_IRQEN] = irq_en;
    reg_rdata_o[BIT_BUSEN] = bus_en;
    reg_rdata_o[BIT_START] = start_req;
    reg_rdata_o[BIT_STOP]  = stop_req;
  end

  assign irq_o      = irq_q;
  assign mode_o     = mode;
  assign bus_free_o = bus_free;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    !irq_en |=> !irq_o); // R2
  AST_SLAVE_HANDS_OFF: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == MODE_SLAVE) |-> (!sda_oe_o && !scl_oe_o)); // R7
  AST_LINE_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    line_start |-> bus_en); // R3
endmodule

// File: tb/twb_cond_seq_tb_top.sv
module twb_cond_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [3:0] reg_wdata;
  logic [3:0] reg_rdata;
  logic       int_flag, byte_done, slave_hit;
  logic       sda_oe, scl_oe, irq;
  logic [1:0] mode;
  logic       bus_free;
  logic       ext_sda_low, ext_scl_low;
  logic       sda_line, scl_line;

  int total = 0;
  int bad   = 0;

  assign sda_line = ~sda_oe & ~ext_sda_low;
  assign scl_line = ~scl_oe & ~ext_scl_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  twb_cond_seq #(.PHASE_CYC(PH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .int_flag_i(int_flag), .byte_done_i(byte_done),
    .slave_hit_i(slave_hit), .sda_i(sda_line), .scl_i(scl_line),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .irq_o(irq), .mode_o(mode),
    .bus_free_o(bus_free)
  );

  // line watcher: event codes 1 = START, 2 = STOP
  logic sda_p = 1'b1, scl_p = 1'b1;
  int   starts = 0, stops = 0, hold_run = 0, last_hold = 0;
  logic [7:0] ev_log = '0;
  always @(negedge clk) begin
    if (scl_p && scl_line && sda_p && !sda_line) begin
      starts <= starts + 1; ev_log <= {ev_log[5:0], 2'd1};
    end
    if (scl_p && scl_line && !sda_p && sda_line) begin
      stops <= stops + 1; ev_log <= {ev_log[5:0], 2'd2};
    end
    if (scl_line && !sda_line) hold_run <= hold_run + 1;
    else hold_run <= 0;
    if (scl_p && !scl_line) last_hold <= hold_run;
    sda_p <= sda_line;
    scl_p <= scl_line;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_mode(input logic [1:0] m);
    for (int i = 0; i < 400 && mode != m; i++) @(negedge clk);
  endtask

  // {wdata[3:0], int_flag, expected rdata[3:0], expected irq}
  localparam logic [9:0] VEC [6] = '{
    {4'b0001, 1'b0, 4'b0001, 1'b0},
    {4'b0001, 1'b1, 4'b0001, 1'b1},
    {4'b0000, 1'b1, 4'b0000, 1'b0},
    {4'b0100, 1'b0, 4'b0100, 1'b0},
    {4'b0000, 1'b1, 4'b0100, 1'b0},
    {4'b0101, 1'b1, 4'b0101, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, p0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    int_flag = 1'b0; byte_done = 1'b0; slave_hit = 1'b0;
    ext_sda_low = 1'b0; ext_scl_low = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 oe", {sda_oe, scl_oe}, 0);
    chk("R1 mode", mode, 0);
    chk("R1 bus_free", bus_free, 1);
    chk("R1 irq", irq, 0);

    // R2 / R5 register and interrupt vectors
    for (int i = 0; i < 6; i++) begin
      int_flag = VEC[i][5];
      wr(VEC[i][9:6]);
      tick(1);
      chk($sformatf("R2 rdata vec%0d", i), reg_rdata, VEC[i][4:1]);
      chk($sformatf("R2 irq vec%0d", i), irq, VEC[i][0]);
    end
    int_flag = 1'b0;

    // R3 bus disabled: line START and slave address ignored, pending start idle
    ext_sda_low = 1'b1; tick(3);
    chk("R3 bus_free kept", bus_free, 1);
    slave_hit = 1'b1; tick(1); slave_hit = 1'b0; tick(2);
    chk("R3 mode idle", mode, 0);
    chk("R3 no drive", {sda_oe, scl_oe}, 0);
    ext_sda_low = 1'b0; tick(3);

    // R4 / R5 START from idle
    s0 = starts;
    wr(4'b0010);
    wait_mode(2'b01);
    tick(1);
    chk("R4 mode master", mode, 1);
    chk("R4 one START", starts, s0 + 1);
    chk("R4 hold length ok", (last_hold >= PH) ? 1 : 0, 1);
    chk("R4 scl held", scl_oe, 1);
    chk("R5 start cleared", reg_rdata[2], 0);

    // R6 repeated START needs a completed byte
    s0 = starts;
    wr(4'b0110);
    tick(30);
    chk("R6 pending", reg_rdata[2], 1);
    chk("R6 no START yet", starts, s0);
    byte_done = 1'b1; tick(1); byte_done = 1'b0;
    for (int i = 0; i < 400 && reg_rdata[2]; i++) @(negedge clk);
    chk("R6 repeated START", starts, s0 + 1);
    chk("R6 still master", mode, 1);

    // R8 STOP in master
    p0 = stops;
    wr(4'b1010);
    wait_mode(2'b00);
    tick(1);
    chk("R8 one STOP", stops, p0 + 1);
    chk("R8 rdata", reg_rdata, 4'b0010);
    chk("R8 released", {sda_oe, scl_oe}, 0);
    chk("R8 bus_free", bus_free, 1);

    // R10 start and stop together in master
    wr(4'b0110);
    wait_mode(2'b01);
    s0 = starts; p0 = stops;
    wr(4'b1110);
    for (int i = 0; i < 600 && (reg_rdata[3:2] != 2'b00); i++) @(negedge clk);
    tick(1);
    chk("R10 STOP then START", ev_log[3:0], 4'b1001);
    chk("R10 counts", (starts - s0) * 10 + (stops - p0), 11);
    chk("R10 master", mode, 1);
    wr(4'b1010);
    wait_mode(2'b00);
    tick(2);

    // R11 / R7 start request during slave access
    ext_sda_low = 1'b1; tick(1); ext_scl_low = 1'b1; tick(1);
    chk("R11 busy after START", bus_free, 0);
    slave_hit = 1'b1; tick(1); slave_hit = 1'b0; tick(1);
    chk("R7 slave", mode, 2);
    s0 = starts;
    wr(4'b0110);
    tick(30);
    chk("R7 waits", (starts - s0) * 10 + reg_rdata[2], 1);
    chk("R7 hands off", {sda_oe, scl_oe}, 0);
    ext_scl_low = 1'b0; tick(2); ext_sda_low = 1'b0;
    wait_mode(2'b01);
    tick(1);
    chk("R7 START after release", starts, s0 + 1);
    chk("R7 master", mode, 1);
    wr(4'b1010);
    wait_mode(2'b00);
    tick(2);

    // R9 stop request in slave mode
    ext_sda_low = 1'b1; tick(1); ext_scl_low = 1'b1; tick(1);
    slave_hit = 1'b1; tick(1); slave_hit = 1'b0; tick(1);
    chk("R9 slave", mode, 2);
    p0 = stops;
    wr(4'b1010);
    tick(2);
    chk("R9 idle", mode, 0);
    chk("R9 stop cleared", reg_rdata[3], 0);
    chk("R9 no STOP driven", stops, p0);
    chk("R9 no drive", {sda_oe, scl_oe}, 0);
    ext_scl_low = 1'b0; tick(2); ext_sda_low = 1'b0; tick(2);
    chk("R11 free after STOP", bus_free, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule